// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block reorders the channels of a framed parallel word stream. A frame has 1024 timeslots. Each slot carries one 16-bit word on `in_word`. Every incoming word is stored in a data memory. For each output slot, a connection memory holds the number of the input slot whose word goes out in that position. Each connection entry also carries a drive-enable bit, which is presented beside the word so that an external bus driver can be switched per slot.

Two delay behaviours can be chosen with `delay_mode`, and the choice is made word by word.

- Minimum-delay mode (0) sends the word received in the current frame when the source slot has already gone by. Otherwise it sends the word from the previous frame. This suits voice traffic.
- Constant-delay mode (1) always sends the previous frame's word. This keeps groups of concatenated channels aligned for data traffic. In this mode, a word switched from slot 1023 into slot 0 is two frames old.

A host port writes and reads connection entries synchronously.

A small state machine handles frame alignment. After reset it is in SEEK, and it stores nothing and drives zeros. The first `frame_sync` pulse takes it to LOCKED (transition SEEK→LOCKED), and it stays there (transition LOCKED→LOCKED). While LOCKED, each `frame_sync` pulse realigns the channel counter. The data memory has two banks that swap at every slot 0. One bank collects the current frame and the other holds the previous frame. The word for the next slot is selected one cycle ahead. When the source slot is the one arriving in that same cycle, the incoming word is forwarded directly.

Top module: `tsi_switch`

## Requirements
- R1: The cycle in which `frame_sync` is high carries input slot 0. Each later cycle carries the next slot, and the count wraps from 1023 to 0. While LOCKED, the word on `out_word` in a cycle belongs to the output slot that follows the previous cycle's input slot, and `out_slot` shows that slot number.
- R2: After reset and until the first `frame_sync`, the block is in SEEK. In SEEK it stores no input, and `out_word`, `out_drive_en` and `out_slot` are all 0. The cycle of the first pulse outputs zeros too.
- R3: In minimum-delay mode (`delay_mode`=0), with source slot s from connection bits 9:0 and output slot o, the output carries the current frame's word when s < o. It carries the previous frame's word when s >= o. Equal slots therefore give the previous frame.
- R4: In constant-delay mode (`delay_mode`=1), every output word is the source slot's word from the previous frame.
- R5: In constant-delay mode, output slot 0 fed from input slot 1023 carries the word from two frames earlier.
- R6: `out_drive_en` equals bit 13 of the connection entry of the slot shown on `out_word`, in the same cycle. Connection bits 15:14 and 12:10 have no effect on the output.
- R7: A host write (`host_we`=1) stores `host_wdata` at `host_addr` at the clock edge. `host_rdata` shows, one cycle later, the entry at the `host_addr` of the previous cycle, read before any write in that cycle. An output slot uses the new entry only if its selection cycle comes after the write cycle.
- R8: A `frame_sync` pulse that arrives before slot 1023 has passed restarts the count at slot 0 and begins a new frame. Later outputs follow R3 to R5 relative to the new frame.
- R9: `delay_mode` is applied per word, in the selection cycle before the word appears. Changing it part way through a frame changes only the words selected from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Marks the cycle carrying input slot 0 |
| delay_mode | input | 1 | 0 = minimum delay, 1 = constant delay |
| in_word | input | 16 | Input word of the current slot |
| host_addr | input | 10 | Connection entry index (output slot) |
| host_we | input | 1 | Connection entry write strobe |
| host_wdata | input | 16 | Connection entry write value |
| host_rdata | output | 16 | Connection entry read value, one cycle after the address |
| out_word | output | 16 | Switched output word |
| out_drive_en | output | 1 | External driver enable for the slot on `out_word` |
| out_slot | output | 10 | Output slot number of `out_word` |

## Verification
A word is selected in the cycle that carries the preceding input slot and appears on `out_word`, `out_drive_en` and `out_slot` after the following clock edge. A host read returns one cycle after its address is presented. The bench drives inputs and samples outputs at the falling edge. At each falling edge it first compares the outputs with the values its behavioural model predicted for that edge, and only then applies the new inputs and steps the model. The model keeps per-frame histories of input words tagged by frame number. A prediction whose source word was never written, or whose connection entry was never set, is left unchecked and is not counted.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Frame alignment states
    typedef enum logic [0:0] {
        ST_SEEK   = 1'b0,
        ST_LOCKED = 1'b1
    } tsi_state_e;

    // Delay behaviour selected on the mode pin
    typedef enum logic [0:0] {
        DLY_MIN   = 1'b0,
        DLY_FIXED = 1'b1
    } tsi_delay_e;

    // Where the selected output word is taken from
    typedef enum logic [1:0] {
        SRC_BYPASS = 2'd0,   // word arriving in this very cycle
        SRC_CUR    = 2'd1,   // bank filling during the current frame
        SRC_OTHER  = 2'd2    // bank holding the previous frame
    } tsi_src_e;

endpackage

// File: rtl/tsi_frame_ctl.sv
// Frame alignment state machine, channel counter and bank toggle.
// NUM_CH must be a power of two so the counter wraps naturally.
module tsi_frame_ctl
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_CH = 1024,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    output logic [CH_W-1:0] cur_ch,
    output logic            cur_bank,
    output logic            lock_next,
    output logic            last_ch
);

    localparam logic [CH_W-1:0] CH_ONE  = CH_W'(1);
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

    tsi_state_e      state_q, state_d;
    logic [CH_W-1:0] cnt_q;
    logic            bank_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK:   state_d = frame_sync ? ST_LOCKED : ST_SEEK;
            ST_LOCKED: state_d = ST_LOCKED;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        cur_ch    = frame_sync ? '0 : cnt_q + CH_ONE;
        cur_bank  = (cur_ch == '0) ? ~bank_q : bank_q;
        lock_next = (state_d == ST_LOCKED);
        last_ch   = (cur_ch == CH_LAST);
    end

    // Counter and bank pointer advance only while aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= CH_LAST;
            bank_q <= 1'b0;
        end else if (lock_next) begin
            cnt_q  <= cur_ch;
            bank_q <= cur_bank;
        end
    end

    // R1
    sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (cnt_q == '0));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !frame_sync) |=> (cnt_q == $past(cnt_q) + CH_ONE));

    // R8
    bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_next && cur_ch == '0) |=> (bank_q != $past(bank_q)));

endmodule

// File: rtl/tsi_conn_mem.sv
// Connection memory with a synchronous host port and a lookup port.
module tsi_conn_mem #(
    parameter int unsigned NUM_CH = 1024,
    parameter int unsigned CM_W   = 16,
    parameter int unsigned OE_BIT = 13,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] host_addr,
    input  logic            host_we,
    input  logic [CM_W-1:0] host_wdata,
    output logic [CM_W-1:0] host_rdata,
    input  logic [CH_W-1:0] look_slot,
    output logic [CH_W-1:0] look_src,
    output logic            look_oe
);

    logic [CM_W-1:0] entry [NUM_CH];

    always_ff @(posedge clk) begin
        if (host_we) entry[host_addr] <= host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= entry[host_addr];
    end

    assign look_src = entry[look_slot][CH_W-1:0];
    assign look_oe  = entry[look_slot][OE_BIT];

    // R7
    wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we ##1 (host_addr == $past(host_addr))) |=> (host_rdata == $past(host_wdata, 2)));

endmodule

// File: rtl/tsi_data_mem.sv
// Two alternating data banks with a same-cycle forward path.
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_CH = 1024,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned BANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [CH_W-1:0]   wr_slot,
    input  logic [DATA_W-1:0] wr_word,
    input  tsi_src_e          rd_src,
    input  logic [CH_W-1:0]   rd_slot,
    output logic [DATA_W-1:0] rd_word
);

    logic [BANKS-1:0][DATA_W-1:0] bank_rd;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] mem [NUM_CH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) mem[wr_slot] <= wr_word;
        end

        assign bank_rd[b] = mem[rd_slot];
    end

    always_comb begin
        unique case (rd_src)
            SRC_BYPASS: rd_word = wr_word;
            SRC_CUR:    rd_word = bank_rd[wr_bank];
            SRC_OTHER:  rd_word = bank_rd[~wr_bank];
            default:    rd_word = '0;
        endcase
    end

    // R3
    bypass_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == SRC_BYPASS && wr_en) |-> (rd_slot == wr_slot));

endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchange switch top level.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_CH = 1024,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CM_W   = 16,
    parameter int unsigned OE_BIT = 13,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              delay_mode,
    input  logic [DATA_W-1:0] in_word,
    input  logic [CH_W-1:0]   host_addr,
    input  logic              host_we,
    input  logic [CM_W-1:0]   host_wdata,
    output logic [CM_W-1:0]   host_rdata,
    output logic [DATA_W-1:0] out_word,
    output logic              out_drive_en,
    output logic [CH_W-1:0]   out_slot
);

    localparam logic [CH_W-1:0] CH_ONE = CH_W'(1);

    logic [CH_W-1:0]   cur_ch;
    logic              cur_bank;
    logic              lock_next;
    logic              last_ch;
    logic [CH_W-1:0]   look_slot;
    logic [CH_W-1:0]   look_src;
    logic              look_oe;
    tsi_src_e          rd_src;
    tsi_delay_e        dly;
    logic [DATA_W-1:0] sel_word;

    tsi_frame_ctl #(.NUM_CH(NUM_CH)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_sync(frame_sync),
        .cur_ch    (cur_ch),
        .cur_bank  (cur_bank),
        .lock_next (lock_next),
        .last_ch   (last_ch)
    );

    // The word for the following slot is chosen one cycle ahead
    assign look_slot = cur_ch + CH_ONE;

    tsi_conn_mem #(.NUM_CH(NUM_CH), .CM_W(CM_W), .OE_BIT(OE_BIT)) u_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_addr (host_addr),
        .host_we   (host_we),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .look_slot (look_slot),
        .look_src  (look_src),
        .look_oe   (look_oe)
    );

    assign dly = tsi_delay_e'(delay_mode);

    // Source selection relative to the slot arriving now
    always_comb begin
        rd_src = SRC_OTHER;
        unique case (dly)
            DLY_MIN: begin
                if (look_src < cur_ch)       rd_src = SRC_CUR;
                else if (look_src == cur_ch) rd_src = SRC_BYPASS;
                else                         rd_src = SRC_OTHER;
            end
            DLY_FIXED: begin
                if (last_ch && (look_src != cur_ch)) rd_src = SRC_CUR;
                else                                 rd_src = SRC_OTHER;
            end
        endcase
    end

    tsi_data_mem #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lock_next),
        .wr_bank(cur_bank),
        .wr_slot(cur_ch),
        .wr_word(in_word),
        .rd_src (rd_src),
        .rd_slot(look_src),
        .rd_word(sel_word)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word     <= '0;
            out_drive_en <= 1'b0;
            out_slot     <= '0;
        end else if (lock_next) begin
            out_word     <= sel_word;
            out_drive_en <= look_oe;
            out_slot     <= look_slot;
        end else begin
            out_word     <= '0;
            out_drive_en <= 1'b0;
            out_slot     <= '0;
        end
    end

    // R2
    seek_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_next |=> (out_word == '0 && !out_drive_en && out_slot == '0));

endmodule

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;

    localparam int NCH = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_sync;
    logic        delay_mode;
    logic [15:0] in_word;
    logic [9:0]  host_addr;
    logic        host_we;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic [15:0] out_word;
    logic        out_drive_en;
    logic [9:0]  out_slot;

    always #4 clk = ~clk;

    tsi_switch u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .delay_mode(delay_mode),
        .in_word(in_word), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .out_word(out_word),
        .out_drive_en(out_drive_en), .out_slot(out_slot)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Behavioural model state
    int hist_val [4][NCH];
    int hist_tag [4][NCH];
    int cm_m [NCH];
    int m_cnt, m_lock, m_fidx;
    int e_word, e_oe, e_slot, e_rd;
    string word_tag;
    int realign_left = 0;
    bit mode_mix = 0;
    int cyc = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        if (exp < 0) return;
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int cm_entry(input int o);
        int src;
        if (o == 5)      src = 3;
        else if (o == 6) src = 6;
        else if (o == 7) src = 8;
        else if (o == 0) src = NCH - 1;
        else             src = (o * 7 + 3) % NCH;
        return src | ((o % 2) << 13) | ((o % 4) << 14) | ((o % 3) << 10);
    endfunction

    // One model step for the inputs applied before the coming edge
    task automatic model_step(input bit sync, input bit mode, input bit we,
                              input int addr, input int wdata, input int word);
        int lock_n, ch, o, fo, cmv, s, fsrc;
        lock_n = (m_lock != 0 || sync) ? 1 : 0;
        ch = sync ? 0 : (m_cnt + 1) % NCH;
        if (lock_n != 0) begin
            if (ch == 0) m_fidx++;
            hist_val[m_fidx % 4][ch] = word;
            hist_tag[m_fidx % 4][ch] = m_fidx;
        end
        if (lock_n == 0) begin
            e_word = 0; e_oe = 0; e_slot = 0; word_tag = "R2";
        end else begin
            o = (ch + 1) % NCH;
            fo = (ch == NCH - 1) ? m_fidx + 1 : m_fidx;
            e_slot = o;
            cmv = cm_m[o];
            if (cmv < 0) begin
                e_word = -1; e_oe = -1; word_tag = "R3";
            end else begin
                s = cmv % NCH;
                e_oe = (cmv >> 13) & 1;
                if (!mode) begin
                    fsrc = (s < o) ? fo : fo - 1;
                    word_tag = "R3";
                end else if (o == 0 && s == NCH - 1) begin
                    fsrc = fo - 2;
                    word_tag = "R5";
                end else begin
                    fsrc = fo - 1;
                    word_tag = "R4";
                end
                if (realign_left > 0) word_tag = "R8";
                else if (mode_mix)    word_tag = "R9";
                if (fsrc >= 0 && hist_tag[fsrc % 4][s] == fsrc) e_word = hist_val[fsrc % 4][s];
                else                                            e_word = -1;
            end
        end
        e_rd = cm_m[addr];
        if (we) cm_m[addr] = wdata;
        if (lock_n != 0) m_cnt = ch;
        m_lock = lock_n;
        if (realign_left > 0) realign_left--;
    endtask

    task automatic cycle(input bit sync, input bit mode, input bit we,
                         input int addr, input int wdata, input int word);
        @(negedge clk);
        chk(word_tag, "out_word", int'(out_word), e_word);
        chk("R6", "out_drive_en", int'(out_drive_en), e_oe);
        chk("R1", "out_slot", int'(out_slot), e_slot);
        chk("R7", "host_rdata", int'(host_rdata), e_rd);
        frame_sync = sync;
        delay_mode = mode;
        host_we    = we;
        host_addr  = 10'(addr);
        host_wdata = 16'(wdata);
        in_word    = 16'(word);
        model_step(sync, mode, we, addr, wdata, word);
        cyc++;
    endtask

    function automatic int gen_word();
        return (cyc * 40503 + 17) & 16'hFFFF;
    endfunction

    // msel: 0 min, 1 constant, 2 alternating inside the frame
    task automatic run_slots(input int count, input int msel, input bit host);
        for (int k = 0; k < count; k++) begin
            bit m;
            bit we;
            int a, wd;
            m  = (msel == 2) ? bit'((k / 97) % 2) : bit'(msel);
            we = host && (k % 61 == 7);
            a  = host ? (k * 13 + 5) % NCH : k % NCH;
            wd = ((k * 3) % NCH) | ((k % 2) << 13);
            cycle(k == 0, m, we, a, wd, gen_word());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 4; f++)
            for (int c = 0; c < NCH; c++) begin
                hist_val[f][c] = 0;
                hist_tag[f][c] = -99;
            end
        for (int c = 0; c < NCH; c++) cm_m[c] = -1;
        m_cnt = NCH - 1; m_lock = 0; m_fidx = -1;
        rst_n = 1'b0; frame_sync = 1'b0; delay_mode = 1'b0; in_word = '0;
        host_addr = '0; host_we = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        // Reset state, R2
        chk("R2", "out_word reset", int'(out_word), 0);
        chk("R2", "out_drive_en reset", int'(out_drive_en), 0);
        chk("R2", "out_slot reset", int'(out_slot), 0);
        chk("R7", "host_rdata reset", int'(host_rdata), 0);
        rst_n = 1'b1;
        word_tag = "R2";
        model_step(0, 0, 0, 0, 0, 0);

        // SEEK: inputs ignored, outputs quiet (R2)
        for (int k = 0; k < 5; k++) cycle(0, 0, 0, 0, 0, gen_word());
        // Program the connection memory (R7)
        for (int o = 0; o < NCH; o++) cycle(0, 0, 1, o, cm_entry(o), gen_word());
        // Read every entry back (R7)
        for (int o = 0; o < NCH; o++) cycle(0, 0, 0, o, 0, gen_word());
        // Same-cycle write and read: old value first (R7)
        cycle(0, 0, 1, 42, cm_entry(42) ^ 16'h8000, gen_word());
        cycle(0, 0, 0, 42, 0, gen_word());
        cycle(0, 0, 1, 42, cm_entry(42), gen_word());

        // Minimum delay (R3), constant delay with wrap (R4, R5)
        repeat (3) run_slots(NCH, 0, 0);
        repeat (3) run_slots(NCH, 1, 0);
        // Mode changed inside frames (R9)
        mode_mix = 1;
        repeat (2) run_slots(NCH, 2, 0);
        mode_mix = 0;
        // Host rewrites during traffic (R7)
        repeat (2) run_slots(NCH, 0, 1);
        run_slots(NCH, 1, 1);
        // Early frame pulse realigns (R8)
        run_slots(500, 1, 0);
        realign_left = NCH + 8;
        run_slots(NCH, 1, 0);
        run_slots(NCH, 0, 0);
        run_slots(NCH, 1, 0);
        cycle(0, 0, 0, 0, 0, gen_word());

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule